// File: doc/BRIEF.md
# Resolver Converter Serial Read Controller

This block is the master side of a serial link to a resolver-to-digital converter. When an external sampling pulse arrives, it sets the converter's two mode pins to select angle or speed output. It waits a programmable settling time and then clocks one 24-bit frame in. That frame carries 16 data bits followed by 8 fault bits, and no address is sent during it. The same sampling pulse may be wired to other converters in the system, so the controller takes it as a single-cycle strobe.

A second path gives access to the converter's internal registers, for example to change its excitation frequency. The controller puts both mode pins high for this. A write sends an address byte with its top bit set, then a data byte. A read sends the address byte twice and keeps the byte that returns during the second frame.

The serial clock is derived from the system clock by division. It idles low. Outgoing bits change on its rising edge and incoming bits are captured on its falling edge. The frame-select line is held low for the whole of each transfer.

Top module: `rdc_serial_ctrl`

## Requirements
- R1: The mode pins {mode_a0, mode_a1} are 00 for an angle read, 01 for a speed read and 11 for any register access. The combination mode_a0=1, mode_a1=0 is never driven.
- R2: An angle or speed read is one frame of exactly 24 serial clock periods with nothing sent first. The first 16 bits received, MSB first, appear on data_word and the last 8 on fault_bits. data_valid is high for exactly one cycle, the same cycle in which busy falls.
- R3: sclk is low whenever fsync_n is high. Each sclk level lasts DIV_HALF system clocks, so the period is 40 ns at the defaults. sdo changes only with a rising sclk edge, and sdi is sampled at the falling edge.
- R4: fsync_n is low from before the first sclk rise until after the last sclk fall of a frame. A register access uses two separate frames, with fsync_n going high between them.
- R5: fsync_n falls on the (settle_cycles+1)-th rising clk edge after the edge that accepts a request. The mode pins do not change while fsync_n is low.
- R6: A register write sends two 8-bit frames. The first is {1, cfg_addr}. The second is cfg_wdata, with bit 7 expected to be 0. cfg_done pulses for one cycle when busy falls.
- R7: A register read sends {1, cfg_addr} in both of its 8-bit frames. cfg_rdata takes the 8 bits received in the second frame, and cfg_done pulses when busy falls.
- R8: busy is high from the accepting edge until the access completes. A sample_trig that arrives while busy starts nothing and is not queued. On the next edge it raises trig_overrun, which stays high for one cycle.
- R9: If sample_trig and cfg_req arrive in the same idle cycle, the read wins and the register request is dropped. A cfg_req while busy is ignored and does not raise trig_overrun.
- R10: After reset, fsync_n=1, sclk=0, mode pins are 00, and busy, data_valid, cfg_done and trig_overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 100 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_trig | input | 1 | One-cycle sampling strobe |
| vel_sel | input | 1 | 1 selects speed, 0 selects angle for the next strobe |
| cfg_req | input | 1 | One-cycle register access request |
| cfg_write | input | 1 | 1 for a write, 0 for a read |
| cfg_addr | input | 7 | Register address (top bit added by the block) |
| cfg_wdata | input | 8 | Register write data |
| settle_cycles | input | 8 | Mode-pin settling time in system clocks |
| sdi | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock |
| fsync_n | output | 1 | Frame select, active low |
| sdo | output | 1 | Serial data to the converter |
| mode_a0 | output | 1 | Mode pin 0 |
| mode_a1 | output | 1 | Mode pin 1 |
| busy | output | 1 | Access in progress |
| data_valid | output | 1 | One-cycle pulse when data_word and fault_bits are new |
| data_word | output | 16 | Angle or speed sample |
| fault_bits | output | 8 | Fault and status bits of the last sample |
| cfg_done | output | 1 | One-cycle pulse when a register access ends |
| cfg_rdata | output | 8 | Byte returned by the last register read |
| trig_overrun | output | 1 | One-cycle pulse for a strobe dropped while busy |

## Verification
Two events can land on the same clock edge: a sampling strobe and a register request that arrive together while the block is idle. The bench provokes this by raising sample_trig and cfg_req in the same cycle. The result is judged at the converter model. It must see exactly one 24-period frame with mode pins 00, data_valid must pulse with the expected word, the targeted register must keep its value, and cfg_done must stay low. The bench also checks the related collision of a strobe arriving while busy, which must give a single frame plus an overrun pulse.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;
  localparam int NORM_BITS = 24;
  localparam int POS_W     = 16;
  localparam int FLT_W     = NORM_BITS - POS_W;
  localparam int CFG_BITS  = 8;
  localparam int AW        = CFG_BITS - 1;
  localparam int BCW       = $clog2(NORM_BITS + 1);

  typedef enum logic [1:0] {OP_POS, OP_VEL, OP_CWR, OP_CRD} rdc_op_e;

  // mode pins as {a0, a1}
  function automatic logic [1:0] op_pins(input rdc_op_e op);
    case (op)
      OP_POS:  return 2'b00;
      OP_VEL:  return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic op_is_cfg(input rdc_op_e op);
    return (op == OP_CWR) || (op == OP_CRD);
  endfunction

  function automatic logic [BCW-1:0] op_bits(input rdc_op_e op);
    return op_is_cfg(op) ? BCW'(CFG_BITS) : BCW'(NORM_BITS);
  endfunction

  // outgoing frame, left aligned, MSB first
  function automatic logic [NORM_BITS-1:0] op_tx(input rdc_op_e op, input logic second,
                                                 input logic [AW-1:0] addr,
                                                 input logic [CFG_BITS-1:0] wdata);
    logic [CFG_BITS-1:0] b;
    if (!op_is_cfg(op)) return '0;
    b = (second && op == OP_CWR) ? wdata : {1'b1, addr};
    return {b, {(NORM_BITS-CFG_BITS){1'b0}}};
  endfunction
endpackage

// File: rtl/rdc_trigger_gate.sv
`timescale 1ns/1ps
module rdc_trigger_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_trig,
  input  logic cfg_req,
  input  logic busy,
  output logic accept_trig,
  output logic accept_cfg,
  output logic trig_overrun
);
  assign accept_trig = sample_trig && !busy;
  assign accept_cfg  = cfg_req && !busy && !sample_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_overrun <= 1'b0;
    else        trig_overrun <= sample_trig && busy;
  end
endmodule

// File: rtl/rdc_frame_engine.sv
`timescale 1ns/1ps
module rdc_frame_engine #(
  parameter  int DIV_HALF = 2,
  parameter  int FW       = 24,
  localparam int DW       = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1,
  localparam int CW       = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] nbits,
  input  logic [FW-1:0] tx_word,
  input  logic          sdi,
  output logic          sclk,
  output logic          fsync_n,
  output logic          sdo,
  output logic          done,
  output logic [FW-1:0] rx_word
);
  logic          active, tail, tick;
  logic [DW-1:0] div_cnt;
  logic [CW-1:0] bit_cnt, nbits_q;
  logic [FW-1:0] tx_sh;

  assign tick = active && (div_cnt == DW'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; tail <= 1'b0; sclk <= 1'b0; fsync_n <= 1'b1; sdo <= 1'b0;
      done <= 1'b0; div_cnt <= '0; bit_cnt <= '0; nbits_q <= '0;
      tx_sh <= '0; rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1; tail <= 1'b0; fsync_n <= 1'b0; sclk <= 1'b0;
        div_cnt <= '0; bit_cnt <= '0; nbits_q <= nbits;
        tx_sh <= tx_word; rx_word <= '0;
      end else if (active) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          if (tail) begin
            active <= 1'b0; fsync_n <= 1'b1; done <= 1'b1;
          end else if (!sclk) begin
            sclk  <= 1'b1;
            sdo   <= tx_sh[FW-1];
            tx_sh <= {tx_sh[FW-2:0], 1'b0};
          end else begin
            sclk    <= 1'b0;
            rx_word <= {rx_word[FW-2:0], sdi};
            if (bit_cnt == nbits_q - 1'b1) tail <= 1'b1;
            else                           bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rdc_serial_ctrl.sv
`timescale 1ns/1ps
module rdc_serial_ctrl
  import rdc_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_trig,
  input  logic                vel_sel,
  input  logic                cfg_req,
  input  logic                cfg_write,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CFG_BITS-1:0] cfg_wdata,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                sdi,
  output logic                sclk,
  output logic                fsync_n,
  output logic                sdo,
  output logic                mode_a0,
  output logic                mode_a1,
  output logic                busy,
  output logic                data_valid,
  output logic [POS_W-1:0]    data_word,
  output logic [FLT_W-1:0]    fault_bits,
  output logic                cfg_done,
  output logic [CFG_BITS-1:0] cfg_rdata,
  output logic                trig_overrun
);
  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_FRAME} st_e;

  st_e                 state;
  rdc_op_e             op, new_op;
  logic                second;
  logic [SETTLE_W-1:0] wait_cnt, settle_q;
  logic [AW-1:0]       addr_q;
  logic [CFG_BITS-1:0] wdata_q;

  // named internal events
  logic                 accept_trig, accept_cfg, frame_start, frame_done;
  logic [NORM_BITS-1:0] frame_rx;

  assign busy        = (state != S_IDLE);
  assign frame_start = (state == S_SETTLE) && (wait_cnt == '0);
  assign new_op      = accept_trig ? (vel_sel ? OP_VEL : OP_POS)
                                   : (cfg_write ? OP_CWR : OP_CRD);

  rdc_trigger_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sample_trig(sample_trig), .cfg_req(cfg_req),
    .busy(busy), .accept_trig(accept_trig), .accept_cfg(accept_cfg),
    .trig_overrun(trig_overrun)
  );

  rdc_frame_engine #(.DIV_HALF(DIV_HALF), .FW(NORM_BITS)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .nbits(op_bits(op)),
    .tx_word(op_tx(op, second, addr_q, wdata_q)), .sdi(sdi),
    .sclk(sclk), .fsync_n(fsync_n), .sdo(sdo), .done(frame_done), .rx_word(frame_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; op <= OP_POS; second <= 1'b0;
      wait_cnt <= '0; settle_q <= '0; addr_q <= '0; wdata_q <= '0;
      mode_a0 <= 1'b0; mode_a1 <= 1'b0;
      data_valid <= 1'b0; data_word <= '0; fault_bits <= '0;
      cfg_done <= 1'b0; cfg_rdata <= '0;
    end else begin
      data_valid <= 1'b0;
      cfg_done   <= 1'b0;
      case (state)
        S_IDLE: if (accept_trig || accept_cfg) begin
          op                 <= new_op;
          {mode_a0, mode_a1} <= op_pins(new_op);
          wait_cnt           <= settle_cycles;
          settle_q           <= settle_cycles;
          second             <= 1'b0;
          state              <= S_SETTLE;
          if (accept_cfg) begin
            addr_q  <= cfg_addr;
            wdata_q <= cfg_wdata;
          end
        end
        S_SETTLE: begin
          if (wait_cnt == '0) state    <= S_FRAME;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        S_FRAME: if (frame_done) begin
          if (op_is_cfg(op) && !second) begin
            second   <= 1'b1;
            wait_cnt <= settle_q;
            state    <= S_SETTLE;
          end else begin
            state <= S_IDLE;
            if (!op_is_cfg(op)) begin
              data_word  <= frame_rx[NORM_BITS-1 -: POS_W];
              fault_bits <= frame_rx[FLT_W-1:0];
              data_valid <= 1'b1;
            end else begin
              cfg_done <= 1'b1;
              if (op == OP_CRD) cfg_rdata <= frame_rx[CFG_BITS-1:0];
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdc_serial_ctrl_chk.sv
`timescale 1ns/1ps
module rdc_serial_ctrl_chk
  import rdc_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_trig,
  input logic                busy,
  input logic                trig_overrun,
  input logic                sclk,
  input logic                fsync_n,
  input logic                mode_a0,
  input logic                mode_a1,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic                data_valid,
  input logic                frame_start
);
  localparam int SCW = SETTLE_W + 2;
  logic [SCW-1:0] pin_age;
  logic [1:0]     pins_q;
  logic           sclk_q;
  logic [BCW-1:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_age <= '0; pins_q <= 2'b00; sclk_q <= 1'b0; rises <= '0;
    end else begin
      pins_q <= {mode_a0, mode_a1};
      sclk_q <= sclk;
      if ({mode_a0, mode_a1} != pins_q) pin_age <= SCW'(1);
      else if (pin_age != '1)           pin_age <= pin_age + 1'b1;
      if (frame_start)                  rises <= '0;
      else if (sclk && !sclk_q)         rises <= rises + 1'b1;
    end
  end

  p_no_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_a0 && !mode_a1));
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_n) |-> rises == ((mode_a0 && mode_a1) ? BCW'(CFG_BITS) : BCW'(NORM_BITS)));
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_n |-> !sclk);
  p_xfer_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync_n |-> busy);
  p_pins_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync_n && $past(!fsync_n)) |-> $stable({mode_a0, mode_a1}));
  p_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync_n) |-> pin_age >= SCW'(settle_cycles));
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_trig && busy) |=> trig_overrun);
endmodule

bind rdc_serial_ctrl rdc_serial_ctrl_chk u_chk (.*);

// File: tb/test_rdc_serial_ctrl.sv
`timescale 1ns/1ps
module test_rdc_serial_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_trig = 1'b0, vel_sel = 1'b0, cfg_req = 1'b0, cfg_write = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, settle_cycles = '0;
  logic sdi = 1'b0;
  logic sclk, fsync_n, sdo, mode_a0, mode_a1, busy, data_valid, cfg_done, trig_overrun;
  logic [15:0] data_word;
  logic [7:0]  fault_bits, cfg_rdata;

  rdc_serial_ctrl i_rdc_serial_ctrl (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [23:0] dev_pos = '0, dev_vel = '0, dsh = '0;
  logic [7:0]  regs [128];
  logic [7:0]  shadow [128];
  logic [7:0]  mrx = '0, last_byte = '0;
  logic [6:0]  ptr = '0;
  logic        last_addr = 1'b0;
  logic [1:0]  mode_at_fall = '0;
  int rises = 0, last_rises = 0, frames = 0, bad_period = 0, stray = 0;
  time last_rise = 0;

  always @(negedge fsync_n) if (rst_n) begin
    mode_at_fall = {mode_a0, mode_a1};
    rises = 0; mrx = '0;
    case ({mode_a0, mode_a1})
      2'b00:   dsh = dev_pos;
      2'b01:   dsh = dev_vel;
      2'b11:   dsh = last_addr ? {regs[ptr], 16'h0} : 24'h0;
      default: dsh = 24'h0;
    endcase
  end
  always @(posedge sclk) begin
    if (fsync_n === 1'b1) stray++;
    else if (fsync_n === 1'b0) begin
      if (rises > 0 && ($time - last_rise) != 40) bad_period++;
      last_rise = $time;
      sdi = dsh[23]; dsh = {dsh[22:0], 1'b0};
      rises++;
    end
  end
  always @(negedge sclk) if (fsync_n === 1'b0) mrx = {mrx[6:0], sdo};
  always @(posedge fsync_n) if (rst_n) begin
    frames++; last_rises = rises; last_byte = mrx;
    if (mode_at_fall == 2'b11) begin
      if (mrx[7]) begin ptr = mrx[6:0]; last_addr = 1'b1; end
      else begin regs[ptr] = mrx; last_addr = 1'b0; end
    end
  end

  // ---------------- cycle monitor ----------------
  int cyc = 0, trig_cyc = 0, fall_cyc = -1, dv_cnt = 0, cd_cnt = 0, ov_cnt = 0;
  logic fsync_prev = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && fsync_prev && !fsync_n && fall_cyc < 0) fall_cyc = cyc;
    fsync_prev = fsync_n;
    if (data_valid) dv_cnt++;
    if (cfg_done) cd_cnt++;
    if (trig_overrun) ov_cnt++;
  end

  // kind 0 angle, 1 speed, 2 reg write, 3 reg read
  // {kind[2], settle[8], addr[7], payload[24]}
  localparam logic [40:0] VEC [0:7] = '{
    {2'd0, 8'd3, 7'h00, 24'hA5C31E},
    {2'd1, 8'd5, 7'h00, 24'h7F0281},
    {2'd2, 8'd2, 7'h11, 24'h00005A},
    {2'd3, 8'd1, 7'h11, 24'h000000},
    {2'd0, 8'd0, 7'h00, 24'h0001FF},
    {2'd3, 8'd4, 7'h05, 24'h000000},
    {2'd2, 8'd7, 7'h7F, 24'h00003C},
    {2'd1, 8'd1, 7'h00, 24'hFFFF00}
  };

  task automatic wait_idle();
    do begin @(negedge clk); #1; end while (busy);
  endtask

  task automatic apply(input logic [1:0] kind, input logic [7:0] st,
                       input logic [6:0] ad, input logic [23:0] pl);
    int f0;
    f0 = frames;
    settle_cycles = st; vel_sel = (kind == 2'd1); cfg_write = (kind == 2'd2);
    cfg_addr = ad; cfg_wdata = pl[7:0];
    if (kind == 2'd0) dev_pos = pl;
    if (kind == 2'd1) dev_vel = pl;
    @(negedge clk); #1;
    trig_cyc = cyc; fall_cyc = -1;
    if (kind < 2) sample_trig = 1'b1; else cfg_req = 1'b1;
    @(negedge clk); #1;
    sample_trig = 1'b0; cfg_req = 1'b0;
    wait_idle();
    check("R5 settle latency", fall_cyc - trig_cyc, st + 2);
    if (kind == 2'd0) check("R1 angle pins", mode_at_fall, 2'b00);
    else if (kind == 2'd1) check("R1 speed pins", mode_at_fall, 2'b01);
    else check("R1 register pins", mode_at_fall, 2'b11);
    if (kind < 2) begin
      check("R2 frame periods", last_rises, 24);
      check("R2 data word", data_word, pl[23:8]);
      check("R2 fault bits", fault_bits, pl[7:0]);
      check("R2 data_valid with busy fall", data_valid, 1);
      check("R4 one frame", frames - f0, 1);
    end else begin
      check("R6 byte frame periods", last_rises, 8);
      check("R4 two frames", frames - f0, 2);
      check("R6 cfg_done with busy fall", cfg_done, 1);
      if (kind == 2'd2) begin
        check("R6 register written", regs[ad], pl[7:0]);
        shadow[ad] = pl[7:0];
      end else begin
        check("R7 read data", cfg_rdata, shadow[ad]);
        check("R7 second address byte", last_byte, {1'b1, ad});
      end
    end
    @(negedge clk); #1;
    check("R2 pulses one cycle", {data_valid, cfg_done}, 2'b00);
  endtask

  initial begin
    int dv0, cd0, ov0, f0;
    for (int i = 0; i < 128; i++) begin
      regs[i] = 8'(i) ^ 8'hC3;
      shadow[i] = 8'(i) ^ 8'hC3;
    end
    repeat (3) @(negedge clk);
    check("R10 fsync_n", fsync_n, 1);
    check("R10 sclk", sclk, 0);
    check("R10 mode pins", {mode_a0, mode_a1}, 2'b00);
    check("R10 flags", {busy, data_valid, cfg_done, trig_overrun}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++)
      apply(VEC[i][40:39], VEC[i][38:31], VEC[i][30:24], VEC[i][23:0]);

    // R8: strobe while busy
    dev_pos = 24'h123456; settle_cycles = 8'd2; vel_sel = 1'b0;
    f0 = frames; dv0 = dv_cnt;
    @(negedge clk); #1; sample_trig = 1'b1;
    @(negedge clk); #1; sample_trig = 1'b0;
    check("R8 busy after accept", busy, 1);
    @(negedge clk); #1; sample_trig = 1'b1;
    @(negedge clk);
    check("R8 overrun raised", trig_overrun, 1);
    #1; sample_trig = 1'b0;
    @(negedge clk);
    check("R8 overrun one cycle", trig_overrun, 0);
    wait_idle();
    check("R8 not queued frames", frames - f0, 1);
    check("R8 not queued samples", dv_cnt - dv0, 1);
    check("R8 data", data_word, 16'h1234);

    // R9: register request while busy is ignored
    dev_vel = 24'hBEEF77; vel_sel = 1'b1; cd0 = cd_cnt; ov0 = ov_cnt;
    @(negedge clk); #1; sample_trig = 1'b1;
    @(negedge clk); #1; sample_trig = 1'b0;
    cfg_write = 1'b1; cfg_addr = 7'h30; cfg_wdata = 8'h11; cfg_req = 1'b1;
    @(negedge clk); #1; cfg_req = 1'b0;
    wait_idle();
    repeat (30) @(negedge clk);
    check("R9 busy request no write", regs[7'h30], shadow[7'h30]);
    check("R9 busy request no done", cd_cnt - cd0, 0);
    check("R9 busy request no overrun", ov_cnt - ov0, 0);
    check("R9 speed data", data_word, 16'hBEEF);

    // R9: strobe and register request in the same idle cycle
    dev_pos = 24'h0F0F3C; vel_sel = 1'b0; f0 = frames; dv0 = dv_cnt; cd0 = cd_cnt;
    cfg_write = 1'b1; cfg_addr = 7'h31; cfg_wdata = 8'h22;
    @(negedge clk); #1; sample_trig = 1'b1; cfg_req = 1'b1;
    @(negedge clk); #1; sample_trig = 1'b0; cfg_req = 1'b0;
    wait_idle();
    repeat (30) @(negedge clk);
    check("R9 coincident single frame", frames - f0, 1);
    check("R9 coincident frame periods", last_rises, 24);
    check("R9 coincident angle pins", mode_at_fall, 2'b00);
    check("R9 coincident data", data_word, 16'h0F0F);
    check("R9 coincident sample count", dv_cnt - dv0, 1);
    check("R9 coincident no write", regs[7'h31], shadow[7'h31]);
    check("R9 coincident no done", cd_cnt - cd0, 0);

    check("R3 sclk period", bad_period, 0);
    check("R3 no sclk outside frame", stray, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule